// File: doc/BRIEF.md
# Display Link Lock Supervisor

This block supervises the start of a display pipeline whose far-end receiver either locks onto the link at start-up or stays unlocked for the whole session. After a start request it enables the pipeline and watches a single lock status, delivered with a valid strobe by whatever bus reads the receiver. If lock is reported within a bounded window, the session is declared good and the status is not looked at again. If the window runs out, the pipeline enable is dropped for a minimum off time and then raised again. A settle period follows, during which status is ignored, and then a fresh lock window opens. After a fixed number of such retries without lock, the block declares a permanent failure and leaves the pipeline disabled.

All waits are parameters counted in clock cycles. The defaults correspond to a 100 MHz clock: a 100 ms lock window, a 200 ms restart bound, a 1 ms off time and three retries. A bench can shrink them. A retry counter is visible at the outputs so that software or a monitor can see how many restarts one session needed.

Top module: `link_lock_supervisor`

## Requirements
- R1: While reset is asserted and after its release with no start request, pipe_en, done and fail are 0 and attempt is 0.
- R2: A start_req sampled while idle, done or failed raises pipe_en in the next cycle, clears done and fail, and sets attempt to 0.
- R3: A sample with status_valid=1 and status_lock=1 in any of the LOCK_WAIT_CYC window cycles, including the last one, sets done in the next cycle with pipe_en held at 1 and attempt unchanged. A lock on the last cycle wins over the timeout.
- R4: status_lock has no effect while status_valid is 0, and a valid sample with status_lock=0 does not end the window.
- R5: When a window ends without lock and attempt is below MAX_RETRY, attempt increments by 1 and pipe_en is 0 for exactly OFF_CYC cycles.
- R6: After pipe_en is raised again, status is ignored for RESTART_CYC cycles, and then a new window of LOCK_WAIT_CYC cycles opens. pipe_en therefore stays high for RESTART_CYC+LOCK_WAIT_CYC cycles when no lock comes.
- R7: When a window ends without lock and attempt equals MAX_RETRY, fail is set, pipe_en goes to 0 and stays 0, and attempt stays at MAX_RETRY.
- R8: Once done is set, status inputs are ignored, and done and pipe_en stay 1 until the next start_req.
- R9: done and fail are never 1 together, and each holds until the next accepted start_req.
- R10: A start_req during a window, an off time or a restart wait is ignored. It neither restarts the window nor clears attempt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | One-cycle request to begin a pipeline session |
| status_valid | input | 1 | Strobe marking a fresh status sample |
| status_lock | input | 1 | Receiver lock flag, meaningful when status_valid is 1 |
| pipe_en | output | 1 | Pipeline enable |
| done | output | 1 | Session locked |
| fail | output | 1 | Retries exhausted without lock |
| attempt | output | $clog2(MAX_RETRY+1) | Number of restarts performed in the current session |

## Verification
Two functions can fall in the same cycle: the arrival of a lock sample and the expiry of the lock window. The bench provokes this by pulsing a valid lock on the final window cycle of a retry. Done must then rise with the attempt count unchanged, and no off interval may appear. A second collision is a start request during a running window. It is judged by measuring the enable pulse length, which must remain exactly one window, and by the final attempt value, which must show that nothing was cleared.

// File: rtl/link_lock_pkg.sv
// Shared types for the link lock supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package link_lock_pkg;

    // Supervisor phases; pipeline enable is decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CHECK   = 3'd1,
        ST_OFF     = 3'd2,
        ST_RESTART = 3'd3,
        ST_LOCKED  = 3'd4,
        ST_FAILED  = 3'd5
    } lk_state_t;

endpackage

// File: rtl/link_lock_timer.sv
// Down-counting interval timer shared by all waiting phases.
// A load of value V gives V+1 cycles until expired is seen with the
// counter at zero; the caller loads N-1 to get an N-cycle phase.
// Assumes: load has priority over counting.
module link_lock_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load a new interval or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/link_lock_retry_cnt.sv
// Restart counter for one session, cleared when a session is started.
// Assumes: the controller never increments past its own limit.
module link_lock_retry_cnt #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Clear on a new session, step on each restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/link_lock_fsm.sv
// Sequencing for the lock supervisor: window, off time, restart wait,
// and the two terminal outcomes. Outputs are decoded from the state
// register, so they change one cycle after the deciding sample.
// Assumes: all interval parameters are at least 1; the timer is loaded
// in the same cycle the state is entered.
module link_lock_fsm
    import link_lock_pkg::*;
#(
    parameter int unsigned LOCK_WAIT_CYC = 10,
    parameter int unsigned OFF_CYC       = 4,
    parameter int unsigned RESTART_CYC   = 8,
    parameter int unsigned MAX_RETRY     = 3,
    parameter int unsigned TW            = 4,
    parameter int unsigned CW            = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          status_valid,
    input  logic          status_lock,
    input  logic          tmr_expired,
    input  logic [CW-1:0] attempt,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          pipe_en,
    output logic          done,
    output logic          fail
);

    localparam logic [TW-1:0] WIN_LOAD = TW'(LOCK_WAIT_CYC - 1);
    localparam logic [TW-1:0] OFF_LOAD = TW'(OFF_CYC - 1);
    localparam logic [TW-1:0] RST_LOAD = TW'(RESTART_CYC - 1);
    localparam logic [CW-1:0] LAST_TRY = CW'(MAX_RETRY);

    lk_state_t st, st_nxt;
    logic      lock_seen;
    logic      idle_like;

    assign lock_seen = status_valid && status_lock;
    assign idle_like = (st == ST_IDLE) || (st == ST_LOCKED) || (st == ST_FAILED);

    // Choose the next phase and the timer/counter actions that go with it.
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (st)
            ST_IDLE, ST_LOCKED, ST_FAILED: begin
                if (start_req) begin
                    st_nxt   = ST_CHECK;
                    tmr_load = 1'b1;
                    tmr_val  = WIN_LOAD;
                    cnt_clr  = 1'b1;
                end
            end
            ST_CHECK: begin
                if (lock_seen) begin
                    st_nxt = ST_LOCKED;
                end else if (tmr_expired) begin
                    if (attempt == LAST_TRY) begin
                        st_nxt = ST_FAILED;
                    end else begin
                        st_nxt   = ST_OFF;
                        tmr_load = 1'b1;
                        tmr_val  = OFF_LOAD;
                        cnt_inc  = 1'b1;
                    end
                end
            end
            ST_OFF: begin
                if (tmr_expired) begin
                    st_nxt   = ST_RESTART;
                    tmr_load = 1'b1;
                    tmr_val  = RST_LOAD;
                end
            end
            ST_RESTART: begin
                if (tmr_expired) begin
                    st_nxt   = ST_CHECK;
                    tmr_load = 1'b1;
                    tmr_val  = WIN_LOAD;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    assign pipe_en = (st == ST_CHECK) || (st == ST_RESTART) || (st == ST_LOCKED);
    assign done    = (st == ST_LOCKED);
    assign fail    = (st == ST_FAILED);

    // R2: an accepted start enables the pipeline with a clean session.
    a_r2_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_like && start_req) |=> (pipe_en && !done && !fail && attempt == '0));

    // R3: a valid lock inside the window completes the session.
    a_r3_lock_done: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && lock_seen) |=> (done && pipe_en && $stable(attempt)));

    // R5: a timeout before the last try starts an off interval and counts it.
    a_r5_retry_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && !lock_seen && tmr_expired && attempt != LAST_TRY)
        |=> (!pipe_en && attempt == $past(attempt) + 1'b1));

    // R5: the enable stays low until the off timer runs out.
    a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && !tmr_expired) |=> !pipe_en);

    // R6: status is ignored while the restart settles.
    a_r6_restart_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESTART && !tmr_expired) |=> (!done && pipe_en));

    // R7: a timeout on the last try is terminal.
    a_r7_give_up: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && !lock_seen && tmr_expired && attempt == LAST_TRY)
        |=> (fail && !pipe_en));

    // R8: done holds until a new start arrives.
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_req) |=> done);

    // R10: a start during a running session leaves the retry count alone.
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_like && start_req && !(st == ST_CHECK && tmr_expired && !lock_seen))
        |=> $stable(attempt));

endmodule

// File: rtl/link_lock_supervisor.sv
// Top of the lock supervisor: after a start, wait for a lock report,
// restart the pipeline on timeout, and give up after MAX_RETRY restarts.
// Assumes: status arrives as a sampled flag with a valid strobe; all
// interval parameters are in clock cycles and at least 1.
module link_lock_supervisor #(
    parameter int unsigned LOCK_WAIT_CYC = 10_000_000,
    parameter int unsigned RESTART_CYC   = 20_000_000,
    parameter int unsigned OFF_CYC       = 100_000,
    parameter int unsigned MAX_RETRY     = 3,
    localparam int unsigned CW           = $clog2(MAX_RETRY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          status_valid,
    input  logic          status_lock,
    output logic          pipe_en,
    output logic          done,
    output logic          fail,
    output logic [CW-1:0] attempt
);

    localparam int unsigned MAX_AB = (LOCK_WAIT_CYC > OFF_CYC) ? LOCK_WAIT_CYC : OFF_CYC;
    localparam int unsigned MAX_T  = (MAX_AB > RESTART_CYC) ? MAX_AB : RESTART_CYC;
    localparam int unsigned TW     = $clog2(MAX_T + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          cnt_clr;
    logic          cnt_inc;

    link_lock_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    link_lock_retry_cnt #(.W(CW)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (attempt)
    );

    link_lock_fsm #(
        .LOCK_WAIT_CYC (LOCK_WAIT_CYC),
        .OFF_CYC       (OFF_CYC),
        .RESTART_CYC   (RESTART_CYC),
        .MAX_RETRY     (MAX_RETRY),
        .TW            (TW),
        .CW            (CW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .status_valid (status_valid),
        .status_lock  (status_lock),
        .tmr_expired  (tmr_expired),
        .attempt      (attempt),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc),
        .pipe_en      (pipe_en),
        .done         (done),
        .fail         (fail)
    );

    // R9: outcomes are exclusive at the ports.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R9: fail holds until a new start arrives.
    a_r9_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start_req) |=> fail);

    // R7: the retry count never exceeds its limit.
    a_r7_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        attempt <= CW'(MAX_RETRY));

endmodule

// File: tb/link_lock_supervisor_bench.sv
// Scoreboard bench: the session driver queues the expected outcome,
// a monitor pops it when done or fail rises and compares.
module link_lock_supervisor_bench;

    localparam int unsigned LW  = 20;
    localparam int unsigned RS  = 8;
    localparam int unsigned OFF = 5;
    localparam int unsigned MR  = 3;
    localparam int unsigned CW  = $clog2(MR + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic          status_valid = 1'b0;
    logic          status_lock = 1'b0;
    logic          pipe_en;
    logic          done;
    logic          fail;
    logic [CW-1:0] attempt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit exp_done;
        bit exp_fail;
        int exp_att;
    } outcome_t;

    outcome_t sb_q[$];

    always #5 clk = ~clk;

    link_lock_supervisor #(
        .LOCK_WAIT_CYC (LW),
        .RESTART_CYC   (RS),
        .OFF_CYC       (OFF),
        .MAX_RETRY     (MR)
    ) u_link_lock_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .status_valid (status_valid),
        .status_lock  (status_lock),
        .pipe_en      (pipe_en),
        .done         (done),
        .fail         (fail),
        .attempt      (attempt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: on each new outcome, pop the expected one and compare.
    bit done_q = 1'b0;
    bit fail_q = 1'b0;
    always @(negedge clk) begin
        if (rst_n && ((done && !done_q) || (fail && !fail_q))) begin
            if (sb_q.size() == 0) begin
                chk("R9 unexpected outcome", 1, 0);
            end else begin
                outcome_t e;
                e = sb_q.pop_front();
                chk("R3/R7 done", int'(done), int'(e.exp_done));
                chk("R7/R9 fail", int'(fail), int'(e.exp_fail));
                chk("R5/R7 attempt", int'(attempt), e.exp_att);
            end
        end
        done_q = done;
        fail_q = fail;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // One start pulse; returns at the first cycle of the window.
    task automatic start_pulse();
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    // Run one session. lock_try < 0 means never lock; d is the window
    // cycle of the lock sample; busy_start pulses start_req mid-window.
    task automatic run_session(input int lock_try, input int d, input bit busy_start);
        outcome_t e;
        int hl;
        int ol;
        if (lock_try >= 0) begin
            e.exp_done = 1'b1; e.exp_fail = 1'b0; e.exp_att = lock_try;
        end else begin
            e.exp_done = 1'b0; e.exp_fail = 1'b1; e.exp_att = MR;
        end
        sb_q.push_back(e);
        start_pulse();
        // R2: enable up, session state clean
        chk("R2 pipe_en after start", int'(pipe_en), 1);
        chk("R2 attempt cleared", int'(attempt), 0);
        chk("R2 done/fail cleared", int'(done | fail), 0);
        for (int a = 0; a <= int'(MR); a++) begin
            hl = 0;
            if (a > 0) begin
                // R6: stray lock during the restart settle is ignored
                status_valid = 1'b1; status_lock = 1'b1;
                @(negedge clk); hl++;
                status_valid = 1'b0; status_lock = 1'b0;
                chk("R6 stray lock ignored", int'(done), 0);
                repeat (RS - 1) begin @(negedge clk); hl++; end
            end
            if (a == lock_try) begin
                repeat (d) @(negedge clk);
                status_valid = 1'b1; status_lock = 1'b1;
                @(negedge clk);
                status_valid = 1'b0; status_lock = 1'b0;
                chk("R3 pipe_en held at lock", int'(pipe_en), 1);
                chk("R3 done at lock", int'(done), 1);
                return;
            end
            // R4: lock without valid, and valid without lock, do nothing
            status_valid = 1'b0; status_lock = 1'b1;
            @(negedge clk); hl++;
            status_valid = 1'b1; status_lock = 1'b0;
            @(negedge clk); hl++;
            status_valid = 1'b0; status_lock = 1'b0;
            if (busy_start && a == 0) start_req = 1'b1;
            @(negedge clk); hl++;
            start_req = 1'b0;
            chk("R4 invalid status ignored", int'(done), 0);
            while (pipe_en) begin @(negedge clk); hl++; end
            chk((a == 0) ? "R10 R3 window length" : "R6 restart+window length",
                hl, (a == 0) ? int'(LW) : int'(RS + LW));
            if (a < int'(MR)) begin
                chk("R5 attempt step", int'(attempt), a + 1);
                ol = 0;
                while (!pipe_en) begin @(negedge clk); ol++; end
                chk("R5 off time", ol, int'(OFF));
            end else begin
                chk("R7 fail set", int'(fail), 1);
                repeat (6) @(negedge clk);
                chk("R7 pipe_en stays low", int'(pipe_en), 0);
                chk("R9 fail persists", int'(fail), 1);
                chk("R9 done clear while failed", int'(done), 0);
            end
        end
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 pipe_en in reset", int'(pipe_en), 0);
        chk("R1 done/fail in reset", int'(done | fail), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pipe_en idle", int'(pipe_en), 0);
        chk("R1 attempt idle", int'(attempt), 0);

        // R3: lock early in the first window
        run_session(0, 3, 1'b0);

        // R8: status after lock is not checked again
        status_valid = 1'b1; status_lock = 1'b0;
        repeat (5) @(negedge clk);
        status_valid = 1'b0;
        chk("R8 done holds", int'(done), 1);
        chk("R8 pipe_en holds", int'(pipe_en), 1);

        // R5 R6: lock on second retry; start from the done state
        run_session(2, 0, 1'b0);
        // R3: lock sample on the very last window cycle of a retry
        run_session(1, LW - 1, 1'b0);
        // R10: start during the first window is ignored
        run_session(1, 4, 1'b1);
        // R7: no lock at all
        run_session(-1, 0, 1'b0);
        // R3: lock on the final allowed retry, starting from failed
        run_session(3, 5, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", sb_q.size(), 0);
        finish_run();
    end

endmodule